// File: doc/BRIEF.md
# Synchronous Clock Stop and Power-Down Gate

This block sits between the free-running internal clock sources of a clock generator and its output buffers. It stops and restarts groups of outputs without glitches. Three active-low request pins drive it: a processor-clock stop, a bus-clock stop and a power-down. Per-output register controls qualify these requests: stoppable masks, enable bits, a bus-stop register bit and a power-down line-release mode. Each group parks in its own level. The differential processor pairs hold true HIGH and complement LOW. The bus clocks, the free-running bus clocks and the auxiliary clocks hold LOW.

All logic runs on one fast master clock `clk`. The internal clock sources arrive as level waveforms that are synchronous to `clk`. Each request pin passes through a two-stage synchronizer. It is then counted on edges of the clock it gates. A gate may open or close only while its source sits at that lane's park level. This means a stop never cuts a pulse short, and a restart never stretches one. Every gated output is registered, so it trails its source by one `clk` cycle.

Top module: `clk_stop_gate`

## Requirements
- R1: After `cpu_stop_n` is low and has passed the two-stage synchronizer, the request must be seen on two falling edges of `cpu_src`. Each stoppable pair then parks with `cpu_t`=1 and `cpu_c`=0. The gate changes only in a cycle where `cpu_src` is 1.
- R2: A pair whose `cpu_stoppable` bit is 0 keeps toggling while the processor stop is active.
- R3: After `cpu_stop_n` returns high, stopped pairs resume within two `cpu_src` periods. A falling edge on `cpu_t` only ever follows a falling edge of `cpu_src`, so no pulse is shortened or stretched.
- R4: The bus stop request is active when the synchronized `pci_stop_n` is low or `pci_run_reg` is 0. It takes effect after one rising edge of `pci_src`. `pci_out` then parks LOW, and its gate changes only while `pci_src` is 0.
- R5: A `pcif_out` bit follows the bus stop only when its `pcif_stoppable` bit is 1. With 0 it runs freely.
- R6: When the bus stop request clears, stopped bus outputs resume within two `pci_src` periods. A rising edge on `pci_out` only ever follows a rising edge of `pci_src`.
- R7: Power-down takes effect when the synchronized `pwr_dn_n` low is seen on two falling edges of `cpu_src` (two rising edges of the complement). All pairs then park `cpu_t`=1, `cpu_c`=0. `pci_out`, `pcif_out` and `aux_out` each hold LOW from their source's next low phase. All outputs resume when `pwr_dn_n` returns high.
- R8: While power-down is in effect and `pd_hiz_mode` is 1, `cpu_oe` is 0 (lines released) and both `cpu_t` and `cpu_c` read 0. `cpu_oe` falls only in a cycle where `pd_hiz_mode` was 1.
- R9: An enable bit of 0 (`cpu_en`, `pci_en`, `pcif_en`, `aux_en`) forces the matching output LOW from the next `clk` cycle, whatever the stop state. For a processor pair, both lines go LOW.
- R10: While `rst_n` is low, every gated output is 0 and `cpu_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_src | input | 1 | Free-running processor clock source (true phase) |
| pci_src | input | 1 | Free-running bus clock source |
| aux_src | input | N_AUX | Free-running auxiliary clock sources |
| cpu_stop_n | input | 1 | Asynchronous processor stop request, active low |
| pci_stop_n | input | 1 | Asynchronous bus stop request, active low |
| pwr_dn_n | input | 1 | Asynchronous power-down request, active low |
| pci_run_reg | input | 1 | Register bus-run bit; 0 stops the bus clocks |
| pd_hiz_mode | input | 1 | 1: release processor lines during power-down |
| cpu_stoppable | input | N_CPU | Per-pair stoppable mask |
| pcif_stoppable | input | N_PCIF | Per free-running bus clock stoppable mask |
| cpu_en | input | N_CPU | Per-pair enable |
| pci_en | input | N_PCI | Per bus clock enable |
| pcif_en | input | N_PCIF | Per free-running bus clock enable |
| aux_en | input | N_AUX | Per auxiliary clock enable |
| cpu_t | output | N_CPU | Gated processor true lines |
| cpu_c | output | N_CPU | Gated processor complement lines |
| cpu_oe | output | 1 | Processor line drive enable; 0 means released |
| pci_out | output | N_PCI | Gated bus clocks |
| pcif_out | output | N_PCIF | Gated free-running bus clocks |
| aux_out | output | N_AUX | Gated auxiliary clocks |

## Verification
The glitch properties assume two things. First, every source waveform changes only at `clk` edges. Second, an enable bit has been steady for two cycles before any edge it judges. The bench meets both: it derives all sources by dividing its own master clock, and it changes enables only at falling edges, with windows that cover at least two cycles. Request pins and mode bits are held for many source periods so that each stop and each release completes. The line-release assertion only relates `cpu_oe` to the mode bit. The bench confirms the parked levels themselves against its reference model.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;
  localparam int SYNC_DEPTH     = 2;
  localparam int CPU_QUAL_EDGES = 2;
  localparam int PCI_QUAL_EDGES = 1;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_e;
endpackage

// File: rtl/cs_req_sync.sv
// Synchronizes an active-low request pin; req is active high.
module cs_req_sync #(
  parameter int DEPTH = clk_stop_pkg::SYNC_DEPTH
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic req
);
  logic [DEPTH-1:0] stages;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stages <= '1;
    else        stages <= {stages[DEPTH-2:0], pin_n};
  end

  assign req = ~stages[DEPTH-1];
endmodule

// File: rtl/cs_edge_qual.sv
// Arms once a held request has been seen on EDGES edges of the gated source.
module cs_edge_qual
  import clk_stop_pkg::*;
#(
  parameter int    EDGES = 2,
  parameter edge_e KIND  = EDGE_FALL
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic req,
  output logic armed
);
  localparam int CW = $clog2(EDGES + 1);

  logic          src_d;
  logic          hit;
  logic [CW-1:0] cnt;

  generate
    if (KIND == EDGE_FALL) begin : g_fall
      assign hit = src_d & ~src;
    end else begin : g_rise
      assign hit = ~src_d & src;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_d <= 1'b0;
      cnt   <= '0;
    end else begin
      src_d <= src;
      if (!req)                             cnt <= '0;
      else if (hit && cnt != CW'(EDGES))    cnt <= cnt + 1'b1;
    end
  end

  assign armed = (cnt == CW'(EDGES));
endmodule

// File: rtl/cs_gate_lane.sv
// Gates WIDTH copies of one source. A gate flips only while src == PARK;
// a held output shows PARK ^ INVERT, a running one src ^ INVERT.
module cs_gate_lane #(
  parameter int WIDTH  = 1,
  parameter bit PARK   = 1'b0,
  parameter bit INVERT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src,
  input  logic [WIDTH-1:0] stop,
  input  logic [WIDTH-1:0] en,
  output logic [WIDTH-1:0] gclk
);
  localparam bit HOLD_LEVEL = PARK ^ INVERT;

  logic [WIDTH-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= '0;
      gclk <= '0;
    end else begin
      for (int b = 0; b < WIDTH; b++) begin
        if (src == PARK) held[b] <= stop[b];
        gclk[b] <= en[b] & (held[b] ? HOLD_LEVEL : (src ^ INVERT));
      end
    end
  end
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate
  import clk_stop_pkg::*;
#(
  parameter int N_CPU     = 2,
  parameter int N_PCI     = 6,
  parameter int N_PCIF    = 2,
  parameter int N_AUX     = 3,
  parameter int SYNC      = SYNC_DEPTH,
  parameter int CPU_EDGES = CPU_QUAL_EDGES,
  parameter int PCI_EDGES = PCI_QUAL_EDGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_src,
  input  logic              pci_src,
  input  logic [N_AUX-1:0]  aux_src,
  input  logic              cpu_stop_n,
  input  logic              pci_stop_n,
  input  logic              pwr_dn_n,
  input  logic              pci_run_reg,
  input  logic              pd_hiz_mode,
  input  logic [N_CPU-1:0]  cpu_stoppable,
  input  logic [N_PCIF-1:0] pcif_stoppable,
  input  logic [N_CPU-1:0]  cpu_en,
  input  logic [N_PCI-1:0]  pci_en,
  input  logic [N_PCIF-1:0] pcif_en,
  input  logic [N_AUX-1:0]  aux_en,
  output logic [N_CPU-1:0]  cpu_t,
  output logic [N_CPU-1:0]  cpu_c,
  output logic              cpu_oe,
  output logic [N_PCI-1:0]  pci_out,
  output logic [N_PCIF-1:0] pcif_out,
  output logic [N_AUX-1:0]  aux_out
);
  logic cpu_req, pci_pin_req, pd_req;
  logic cpu_armed, pci_armed, pd_armed;
  logic hiz_q;
  logic [N_CPU-1:0]  cpu_stop_v, t_raw, c_raw;
  logic [N_PCI-1:0]  pci_stop_v;
  logic [N_PCIF-1:0] pcif_stop_v;

  // request synchronizers
  cs_req_sync #(.DEPTH(SYNC)) u_sync_cpu (.clk(clk), .rst_n(rst_n), .pin_n(cpu_stop_n), .req(cpu_req));
  cs_req_sync #(.DEPTH(SYNC)) u_sync_pci (.clk(clk), .rst_n(rst_n), .pin_n(pci_stop_n), .req(pci_pin_req));
  cs_req_sync #(.DEPTH(SYNC)) u_sync_pd  (.clk(clk), .rst_n(rst_n), .pin_n(pwr_dn_n),   .req(pd_req));

  // edge qualification in the domain of the gated clock
  cs_edge_qual #(.EDGES(CPU_EDGES), .KIND(EDGE_FALL)) u_qual_cpu (
    .clk(clk), .rst_n(rst_n), .src(cpu_src), .req(cpu_req), .armed(cpu_armed));
  cs_edge_qual #(.EDGES(CPU_EDGES), .KIND(EDGE_FALL)) u_qual_pd (
    .clk(clk), .rst_n(rst_n), .src(cpu_src), .req(pd_req), .armed(pd_armed));
  cs_edge_qual #(.EDGES(PCI_EDGES), .KIND(EDGE_RISE)) u_qual_pci (
    .clk(clk), .rst_n(rst_n), .src(pci_src), .req(pci_pin_req | ~pci_run_reg), .armed(pci_armed));

  assign cpu_stop_v  = ({N_CPU{cpu_armed}} & cpu_stoppable) | {N_CPU{pd_armed}};
  assign pci_stop_v  = {N_PCI{pci_armed | pd_armed}};
  assign pcif_stop_v = ({N_PCIF{pci_armed}} & pcif_stoppable) | {N_PCIF{pd_armed}};

  // line-release flag, moved only while the true phase is at its park level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hiz_q <= 1'b0;
    else if (cpu_src) hiz_q <= pd_armed & pd_hiz_mode;
  end

  cs_gate_lane #(.WIDTH(N_CPU), .PARK(1'b1), .INVERT(1'b0)) u_lane_cpu_t (
    .clk(clk), .rst_n(rst_n), .src(cpu_src), .stop(cpu_stop_v), .en(cpu_en), .gclk(t_raw));
  cs_gate_lane #(.WIDTH(N_CPU), .PARK(1'b1), .INVERT(1'b1)) u_lane_cpu_c (
    .clk(clk), .rst_n(rst_n), .src(cpu_src), .stop(cpu_stop_v), .en(cpu_en), .gclk(c_raw));

  assign cpu_t  = t_raw & {N_CPU{~hiz_q}};
  assign cpu_c  = c_raw & {N_CPU{~hiz_q}};
  assign cpu_oe = ~hiz_q;

  cs_gate_lane #(.WIDTH(N_PCI), .PARK(1'b0), .INVERT(1'b0)) u_lane_pci (
    .clk(clk), .rst_n(rst_n), .src(pci_src), .stop(pci_stop_v), .en(pci_en), .gclk(pci_out));
  cs_gate_lane #(.WIDTH(N_PCIF), .PARK(1'b0), .INVERT(1'b0)) u_lane_pcif (
    .clk(clk), .rst_n(rst_n), .src(pci_src), .stop(pcif_stop_v), .en(pcif_en), .gclk(pcif_out));

  generate
    for (genvar k = 0; k < N_AUX; k++) begin : g_aux
      cs_gate_lane #(.WIDTH(1), .PARK(1'b0), .INVERT(1'b0)) u_lane_aux (
        .clk(clk), .rst_n(rst_n), .src(aux_src[k]), .stop(pd_armed),
        .en(aux_en[k]), .gclk(aux_out[k]));
    end
  endgenerate
endmodule

// File: rtl/clk_stop_gate_chk.sv
module clk_stop_gate_chk #(
  parameter int N_CPU = 2,
  parameter int N_PCI = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_src,
  input logic             pci_src,
  input logic             pd_hiz_mode,
  input logic [N_CPU-1:0] cpu_en,
  input logic [N_PCI-1:0] pci_en,
  input logic [N_CPU-1:0] cpu_t,
  input logic [N_CPU-1:0] cpu_c,
  input logic             cpu_oe,
  input logic [N_PCI-1:0] pci_out
);
  logic [1:0] age;
  logic       live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end
  assign live = (age == 2'd3);

  AST_EN_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> ((pci_out & ~$past(pci_en)) == '0) && ((cpu_t & ~$past(cpu_en)) == '0)); // R9

  AST_RELEASE_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    live && $fell(cpu_oe) |-> $past(pd_hiz_mode)); // R8

  generate
    for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
      AST_CPU_PAIR_OPPOSED: assert property (@(posedge clk) disable iff (!rst_n)
        live && $past(cpu_en[i]) && cpu_oe |-> cpu_t[i] != cpu_c[i]); // R1
      AST_CPU_NO_RUNT: assert property (@(posedge clk) disable iff (!rst_n)
        live && $fell(cpu_t[i]) && $past(cpu_en[i]) && $past(cpu_en[i], 2) && cpu_oe && $past(cpu_oe)
        |-> !$past(cpu_src) && $past(cpu_src, 2)); // R3
    end
    for (genvar j = 0; j < N_PCI; j++) begin : g_pci
      AST_PCI_NO_RUNT: assert property (@(posedge clk) disable iff (!rst_n)
        live && $rose(pci_out[j]) && $past(pci_en[j]) && $past(pci_en[j], 2)
        |-> $past(pci_src) && !$past(pci_src, 2)); // R6
    end
  endgenerate
endmodule

bind clk_stop_gate clk_stop_gate_chk #(.N_CPU(N_CPU), .N_PCI(N_PCI)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_src(cpu_src), .pci_src(pci_src),
  .pd_hiz_mode(pd_hiz_mode), .cpu_en(cpu_en), .pci_en(pci_en),
  .cpu_t(cpu_t), .cpu_c(cpu_c), .cpu_oe(cpu_oe), .pci_out(pci_out));

// File: tb/test_clk_stop_gate.sv
`timescale 1ns/1ps
module test_clk_stop_gate;
  localparam int NC = 2, NP = 6, NF = 2, NA = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, cpu_src, pci_src, cpu_stop_n, pci_stop_n, pwr_dn_n, pci_run_reg, pd_hiz_mode;
  logic [NA-1:0] aux_src, aux_en, aux_out;
  logic [NC-1:0] cpu_stoppable, cpu_en, cpu_t, cpu_c;
  logic [NF-1:0] pcif_stoppable, pcif_en, pcif_out;
  logic [NP-1:0] pci_en, pci_out;
  logic cpu_oe;

  clk_stop_gate #(.N_CPU(NC), .N_PCI(NP), .N_PCIF(NF), .N_AUX(NA)) i_clk_stop_gate (
    .clk(clk), .rst_n(rst_n), .cpu_src(cpu_src), .pci_src(pci_src), .aux_src(aux_src),
    .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .pwr_dn_n(pwr_dn_n),
    .pci_run_reg(pci_run_reg), .pd_hiz_mode(pd_hiz_mode), .cpu_stoppable(cpu_stoppable),
    .pcif_stoppable(pcif_stoppable), .cpu_en(cpu_en), .pci_en(pci_en), .pcif_en(pcif_en),
    .aux_en(aux_en), .cpu_t(cpu_t), .cpu_c(cpu_c), .cpu_oe(cpu_oe), .pci_out(pci_out),
    .pcif_out(pcif_out), .aux_out(aux_out));

  int checks = 0, failures = 0, cyc = 0;
  string tag = "R10";
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  bit [2:0] ms1, ms2;            // {pd, pci, cpu} pin histories
  int ccnt, pcnt, dcnt;
  bit pc_prev, pp_prev, h_iz;
  bit [NC-1:0] h_cpu, e_t, e_c;
  bit [NP-1:0] h_pci, e_pci;
  bit [NF-1:0] h_f, e_f;
  bit [NA-1:0] h_a, e_a;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms1 = '1; ms2 = '1; ccnt = 0; pcnt = 0; dcnt = 0; pc_prev = 0; pp_prev = 0; h_iz = 0;
      h_cpu = '0; e_t = '0; e_c = '0; h_pci = '0; e_pci = '0; h_f = '0; e_f = '0; h_a = '0; e_a = '0;
    end else begin
      bit cq, pq, dq, creq, preq, dreq, cfall, prise;
      cq = (ccnt == 2); pq = (pcnt == 1); dq = (dcnt == 2);
      for (int i = 0; i < NC; i++) begin
        e_t[i] = cpu_en[i] && (h_cpu[i] ? 1'b1 : cpu_src);
        e_c[i] = cpu_en[i] && (h_cpu[i] ? 1'b0 : !cpu_src);
      end
      for (int j = 0; j < NP; j++) e_pci[j] = pci_en[j] && !h_pci[j] && pci_src;
      for (int j = 0; j < NF; j++) e_f[j] = pcif_en[j] && !h_f[j] && pci_src;
      for (int k = 0; k < NA; k++) e_a[k] = aux_en[k] && !h_a[k] && aux_src[k];
      if (cpu_src) begin
        for (int i = 0; i < NC; i++) h_cpu[i] = (cq && cpu_stoppable[i]) || dq;
        h_iz = dq && pd_hiz_mode;
      end
      if (!pci_src) begin
        for (int j = 0; j < NP; j++) h_pci[j] = pq || dq;
        for (int j = 0; j < NF; j++) h_f[j] = (pq && pcif_stoppable[j]) || dq;
      end
      for (int k = 0; k < NA; k++) if (!aux_src[k]) h_a[k] = dq;
      creq = !ms2[0]; preq = !ms2[1] || !pci_run_reg; dreq = !ms2[2];
      cfall = pc_prev && !cpu_src; prise = !pp_prev && pci_src;
      if (!creq) ccnt = 0; else if (cfall && ccnt < 2) ccnt++;
      if (!preq) pcnt = 0; else if (prise && pcnt < 1) pcnt++;
      if (!dreq) dcnt = 0; else if (cfall && dcnt < 2) dcnt++;
      pc_prev = cpu_src; pp_prev = pci_src;
      ms2 = ms1; ms1 = {pwr_dn_n, pci_stop_n, cpu_stop_n};
    end
  end

  // compare every cycle, then advance the source waveforms
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [NC-1:0] xt, xc;
      xt = e_t & {NC{!h_iz}}; xc = e_c & {NC{!h_iz}};
      chk({cpu_oe, cpu_t, cpu_c} == {!h_iz, xt, xc}, tag, "cpu lines {oe,t,c}",
          {cpu_oe, cpu_t, cpu_c}, {!h_iz, xt, xc});
      chk(pci_out == e_pci, tag, "pci_out", pci_out, e_pci);
      chk(pcif_out == e_f, tag, "pcif_out", pcif_out, e_f);
      chk(aux_out == e_a, tag, "aux_out", aux_out, e_a);
    end
    cyc++;
    cpu_src = cyc[1];
    pci_src = cyc[2];
    for (int k = 0; k < NA; k++) aux_src[k] = ((cyc / (3 + k)) % 2) == 1;
  end

  // ---------------- observation windows ----------------
  int hi_t[NC], tg_t[NC], hi_c[NC], hi_p[NP], tg_p[NP], hi_f[NF], tg_f[NF], hi_a[NA], lo_oe;

  task automatic window(input int n);
    logic [NC-1:0] pt; logic [NP-1:0] pp; logic [NF-1:0] pf;
    for (int i = 0; i < NC; i++) begin hi_t[i] = 0; tg_t[i] = 0; hi_c[i] = 0; end
    for (int j = 0; j < NP; j++) begin hi_p[j] = 0; tg_p[j] = 0; end
    for (int j = 0; j < NF; j++) begin hi_f[j] = 0; tg_f[j] = 0; end
    for (int k = 0; k < NA; k++) hi_a[k] = 0;
    lo_oe = 0;
    pt = cpu_t; pp = pci_out; pf = pcif_out;
    repeat (n) begin
      @(negedge clk);
      for (int i = 0; i < NC; i++) begin
        hi_t[i] += cpu_t[i]; hi_c[i] += cpu_c[i]; tg_t[i] += (cpu_t[i] != pt[i]);
      end
      for (int j = 0; j < NP; j++) begin hi_p[j] += pci_out[j]; tg_p[j] += (pci_out[j] != pp[j]); end
      for (int j = 0; j < NF; j++) begin hi_f[j] += pcif_out[j]; tg_f[j] += (pcif_out[j] != pf[j]); end
      for (int k = 0; k < NA; k++) hi_a[k] += aux_out[k];
      lo_oe += !cpu_oe;
      pt = cpu_t; pp = pci_out; pf = pcif_out;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; cpu_stop_n = 1; pci_stop_n = 1; pwr_dn_n = 1; pci_run_reg = 1; pd_hiz_mode = 0;
    cpu_stoppable = 2'b01; pcif_stoppable = 2'b01;
    cpu_en = '1; pci_en = '1; pcif_en = '1; aux_en = '1;
    cpu_src = 0; pci_src = 0; aux_src = '0;
    idle(3);
    chk(cpu_t == 0 && cpu_c == 0 && cpu_oe && pci_out == 0 && pcif_out == 0 && aux_out == 0,
        "R10", "reset outputs", {cpu_oe, cpu_t, cpu_c, pci_out}, {1'b1, 10'h0});
    @(negedge clk) rst_n = 1;

    tag = "R3"; idle(20); window(16);
    chk(tg_t[0] >= 6, "R3", "pair0 toggles while running", tg_t[0], 6);

    tag = "R1"; cpu_stop_n = 0; idle(20); window(12);
    chk(hi_t[0] == 12 && hi_c[0] == 0, "R1", "pair0 parked t-high count", hi_t[0], 12);
    chk(tg_t[1] >= 4, "R2", "non-stoppable pair1 toggles", tg_t[1], 4);

    tag = "R3"; cpu_stop_n = 1; idle(10); window(12);
    chk(tg_t[0] >= 4, "R3", "pair0 resumed toggles", tg_t[0], 4);

    tag = "R4"; pci_run_reg = 0; idle(24); window(16);
    for (int j = 0; j < NP; j++) chk(hi_p[j] == 0, "R4", "pci_out high count (reg stop)", hi_p[j], 0);
    chk(tg_f[1] >= 3, "R5", "free pcif1 toggles", tg_f[1], 3);
    chk(hi_f[0] == 0, "R5", "stoppable pcif0 high count", hi_f[0], 0);

    tag = "R6"; pci_run_reg = 1; idle(18); window(16);
    for (int j = 0; j < NP; j++) chk(tg_p[j] >= 3, "R6", "pci_out resumed toggles", tg_p[j], 3);
    chk(tg_f[0] >= 3, "R6", "pcif0 resumed toggles", tg_f[0], 3);

    tag = "R4"; pci_stop_n = 0; idle(24); window(16);
    chk(hi_p[0] == 0 && hi_p[NP-1] == 0, "R4", "pci_out high count (pin stop)", hi_p[0], 0);
    pci_stop_n = 1; idle(20);

    tag = "R7"; pwr_dn_n = 0; idle(24); window(12);
    chk(hi_t[0] == 12 && hi_t[1] == 12 && hi_c[0] == 0 && hi_c[1] == 0 && lo_oe == 0,
        "R7", "cpu parked t-high count", hi_t[1], 12);
    chk(hi_p[3] == 0 && hi_f[1] == 0, "R7", "bus clocks held low", hi_p[3] + hi_f[1], 0);
    chk(hi_a[0] + hi_a[1] + hi_a[2] == 0, "R7", "aux held low", hi_a[0] + hi_a[1] + hi_a[2], 0);

    tag = "R8"; pd_hiz_mode = 1; idle(10); window(12);
    chk(lo_oe == 12, "R8", "cycles with lines released", lo_oe, 12);
    chk(hi_t[0] + hi_t[1] + hi_c[0] + hi_c[1] == 0, "R8", "released lines read zero",
        hi_t[0] + hi_t[1], 0);

    tag = "R7"; pwr_dn_n = 1; pd_hiz_mode = 0; idle(24); window(16);
    chk(lo_oe == 0 && tg_t[0] >= 4 && tg_p[0] >= 3, "R7", "all running after power-up",
        tg_t[0], 4);

    tag = "R9"; cpu_stop_n = 0; cpu_en[0] = 0; pci_en[2] = 0; aux_en[0] = 0; pcif_en[1] = 0;
    idle(20); window(12);
    chk(hi_t[0] == 0 && hi_c[0] == 0, "R9", "disabled stopped pair0 lines high count",
        hi_t[0] + hi_c[0], 0);
    chk(hi_p[2] == 0 && hi_f[1] == 0 && hi_a[0] == 0, "R9", "disabled outputs high count",
        hi_p[2] + hi_f[1] + hi_a[0], 0);
    chk(tg_t[1] >= 4, "R9", "enabled pair1 still toggles", tg_t[1], 4);

    cpu_stop_n = 1; cpu_en = '1; pci_en = '1; aux_en = '1; pcif_en = '1;
    idle(20);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 200000, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule